// File: doc/BRIEF.md
# Serial ADC Host Readout Controller

This block sits on the host side of a 12-bit successive-approximation converter that has a two-wire serial output. It starts each conversion with an active-low convert-start strobe at a programmable sample period. It then watches the converter's busy line, and once the conversion has finished it clocks out one 16-bit frame on a serial clock that it generates itself. Each finished frame is delivered as a 12-bit word together with a one-cycle valid strobe.

There are two power modes, chosen per conversion. In fast mode the strobe is a short low pulse that returns high well before the conversion ends, so the converter stays awake. In sleep mode the strobe is held low until the busy line falls, which lets the converter power down between samples; its rising edge at release starts the wake-up. A frame carries four leading zeros ahead of the data. A one in any of those positions is reported as a protocol error. A busy line that never completes its high-then-low sequence is reported as a timeout.

Top module: `adc_readout_ctrl`

## Requirements
- R1: After reset, the strobe is high, the serial clock is low, and the result, the valid strobe and both error outputs are all zero.
- R2: In fast mode (mode_i = 0) the strobe is low for exactly CNV_LOW_CYC clock cycles, and it is high when the busy line falls.
- R3: In sleep mode (mode_i = 1) the strobe stays low from its falling edge until the busy line has fallen, and it is released only after that.
- R4: Serial clocking begins only after busy has been seen high and then low. The serial clock never goes high while the synchronised busy level is high.
- R5: Each frame has exactly 16 serial clock pulses. Each pulse is SCK_HI_CYC cycles high after SCK_LO_CYC cycles low. The clock idles low and is left low after the last pulse.
- R6: A data bit is captured in the clock edge where the serial clock falls. The first captured bit is frame bit 15 and the last is frame bit 0. The result is frame bits 11..0, with bit 11 as the data MSB.
- R7: err_proto_o pulses together with result_valid_o when any of frame bits 15..12 (the four leading bits) is one. The result is still delivered.
- R8: result_valid_o is a one-cycle pulse, and result_o changes only in a cycle where result_valid_o is high.
- R9: Successive strobe falling edges are exactly period_i cycles apart when the readout fits in that period. Otherwise the next falling edge waits until the readout has completed. Periods below 2 act as 2.
- R10: If busy has not completed high-then-low within BUSY_TIMEOUT cycles of the strobe falling edge, err_timeout_o pulses exactly BUSY_TIMEOUT cycles after that edge. No result is produced, the strobe is released, and the sample period continues.
- R11: While enable_i is low no new conversion starts, and a frame already in progress still completes and delivers its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Allows new conversions to start |
| mode_i | input | 1 | 0 = fast mode, 1 = sleep mode; latched at each conversion start |
| period_i | input | PERIOD_W | Sample period in clock cycles |
| adc_busy_i | input | 1 | Busy line from the converter |
| adc_sdata_i | input | 1 | Serial data line from the converter |
| adc_convst_n_o | output | 1 | Active-low convert-start strobe |
| adc_sclk_o | output | 1 | Serial clock to the converter |
| result_o | output | DATA_W | Last conversion result |
| result_valid_o | output | 1 | One-cycle pulse when result_o updates |
| err_timeout_o | output | 1 | One-cycle pulse when the busy timeout expires |
| err_proto_o | output | 1 | One-cycle pulse when a leading bit was one |

## Verification
Several properties are checked on every cycle by assertions:
- the strobe level at the busy falling edge in each power mode;
- the hold of the strobe in sleep mode while waiting for busy;
- that the serial clock stays low outside readout and while busy is high;
- the single-cycle valid pulse and a result that does not change between pulses;
- that the strobe is released after a timeout.

Other behaviours show only in the bench's scenarios: the bit order and the lead-bit check against a converter model, the exact pulse count and phase widths of the serial clock, the cycle spacing of strobes for long and short periods, the exact cycle of the timeout for a silent or a stuck busy line, and the completion of a frame after enable is dropped.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_READ = 2'd2,
    ST_GAP  = 2'd3
  } rd_state_e;

  typedef enum logic {
    PWR_FAST  = 1'b0,
    PWR_SLEEP = 1'b1
  } pwr_mode_e;

  // Clamp a parameter to a lower bound.
  function automatic int unsigned at_least(input int unsigned v, input int unsigned lo);
    return (v < lo) ? lo : v;
  endfunction

  // True once enough cycles have elapsed since the last strobe (period floor 2).
  function automatic logic period_due(input logic [31:0] elapsed, input logic [31:0] period);
    logic [31:0] eff;
    eff = (period < 32'd2) ? 32'd2 : period;
    return elapsed >= (eff - 32'd1);
  endfunction

  // True if any of the top lead_bits of a frame_bits-wide word is one.
  function automatic logic lead_nonzero(input logic [63:0] word, input int frame_bits,
                                        input int lead_bits);
    logic r;
    r = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (i >= frame_bits - lead_bits && i < frame_bits && word[i]) r = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/adc_rd_convst.sv
module adc_rd_convst
  import adc_rd_pkg::*;
#(
  parameter int unsigned LOW_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic sleep_i,
  input  logic busy_fall_i,
  input  logic abort_i,
  output logic convst_n_o
);
  localparam int unsigned LOW_EFF = at_least(LOW_CYC, 1);
  localparam int unsigned CW      = $clog2(LOW_EFF + 1);

  logic [CW-1:0] low_cnt;
  logic          min_met;
  logic          release_now;

  assign min_met = (low_cnt >= CW'(LOW_EFF - 1));

  always_comb begin
    release_now = abort_i;
    if (!sleep_i && min_met) release_now = 1'b1;
    if (sleep_i && busy_fall_i) release_now = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      convst_n_o <= 1'b1;
      low_cnt    <= '0;
    end else if (start_i) begin
      convst_n_o <= 1'b0;
      low_cnt    <= '0;
    end else if (!convst_n_o) begin
      if (release_now) convst_n_o <= 1'b1;
      if (!min_met) low_cnt <= low_cnt + 1'b1;
    end
  end

  // R2: a new strobe is never requested while the previous one is still low
  a_r2_no_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> convst_n_o);

endmodule

// File: rtl/adc_rd_busywatch.sv
module adc_rd_busywatch
  import adc_rd_pkg::*;
#(
  parameter int unsigned TIMEOUT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic busy_i,
  output logic busy_lvl_o,
  output logic fall_o,
  output logic timeout_o
);
  localparam int unsigned TO_EFF = at_least(TIMEOUT, 2);
  localparam int unsigned TW     = $clog2(TO_EFF + 1);

  logic          armed;
  logic          seen_hi;
  logic [TW-1:0] tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_lvl_o <= 1'b0;
      armed      <= 1'b0;
      seen_hi    <= 1'b0;
      tcnt       <= '0;
      fall_o     <= 1'b0;
      timeout_o  <= 1'b0;
    end else begin
      busy_lvl_o <= busy_i;
      fall_o     <= 1'b0;
      timeout_o  <= 1'b0;
      if (arm_i) begin
        armed   <= 1'b1;
        seen_hi <= 1'b0;
        tcnt    <= '0;
      end else if (armed) begin
        if (seen_hi && !busy_lvl_o) begin
          fall_o <= 1'b1;
          armed  <= 1'b0;
        end else if (tcnt == TW'(TO_EFF - 1)) begin
          timeout_o <= 1'b1;
          armed     <= 1'b0;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
        if (busy_lvl_o) seen_hi <= 1'b1;
      end
    end
  end

  // R4: a completed busy sequence is reported with busy already low
  a_r4_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> !$past(busy_lvl_o));

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter
  import adc_rd_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned HI_CYC     = 5,
  parameter int unsigned LO_CYC     = 5,
  parameter int unsigned MIN_PHASE  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go_i,
  input  logic                  sdata_i,
  output logic                  sclk_o,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  done_o
);
  localparam int unsigned HI_EFF = at_least(HI_CYC, MIN_PHASE);
  localparam int unsigned LO_EFF = at_least(LO_CYC, MIN_PHASE);
  localparam int unsigned PH_MAX = (HI_EFF > LO_EFF) ? HI_EFF : LO_EFF;
  localparam int unsigned PW     = $clog2(PH_MAX + 1);
  localparam int unsigned BW     = $clog2(FRAME_BITS + 1);

  logic          active;
  logic [PW-1:0] ph_cnt;
  logic [BW-1:0] bit_cnt;
  logic          last_bit;

  assign last_bit = (bit_cnt == BW'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      sclk_o  <= 1'b0;
      ph_cnt  <= '0;
      bit_cnt <= '0;
      frame_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        active  <= 1'b1;
        sclk_o  <= 1'b0;
        ph_cnt  <= '0;
        bit_cnt <= '0;
      end else if (active) begin
        if (!sclk_o) begin
          if (ph_cnt == PW'(LO_EFF - 1)) begin
            sclk_o <= 1'b1;
            ph_cnt <= '0;
          end else begin
            ph_cnt <= ph_cnt + 1'b1;
          end
        end else if (ph_cnt == PW'(HI_EFF - 1)) begin
          // falling edge: capture the bit that is still held on the line
          sclk_o  <= 1'b0;
          ph_cnt  <= '0;
          frame_o <= {frame_o[FRAME_BITS-2:0], sdata_i};
          bit_cnt <= bit_cnt + 1'b1;
          if (last_bit) begin
            active <= 1'b0;
            done_o <= 1'b1;
          end
        end else begin
          ph_cnt <= ph_cnt + 1'b1;
        end
      end
    end
  end

  // R5: the clock is left low when the frame ends
  a_r5_end_low: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !sclk_o);

endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_rd_pkg::*;
#(
  parameter int unsigned DATA_W       = 12,
  parameter int unsigned LEAD_BITS    = 4,
  parameter int unsigned PERIOD_W     = 16,
  parameter int unsigned CNV_LOW_CYC  = 4,
  parameter int unsigned SCK_HI_CYC   = 5,
  parameter int unsigned SCK_LO_CYC   = 5,
  parameter int unsigned SCK_MIN_PH   = 5,
  parameter int unsigned BUSY_TIMEOUT = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable_i,
  input  logic                mode_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                adc_busy_i,
  input  logic                adc_sdata_i,
  output logic                adc_convst_n_o,
  output logic                adc_sclk_o,
  output logic [DATA_W-1:0]   result_o,
  output logic                result_valid_o,
  output logic                err_timeout_o,
  output logic                err_proto_o
);
  localparam int unsigned FRAME_BITS = DATA_W + LEAD_BITS;

  rd_state_e             state;
  pwr_mode_e             mode_q;
  logic [PERIOD_W-1:0]   per_cnt;
  logic                  due;
  logic                  start;
  logic                  busy_lvl;
  logic                  busy_fall;
  logic                  busy_to;
  logic                  shift_done;
  logic [FRAME_BITS-1:0] frame;

  assign due   = period_due(32'(per_cnt), 32'(period_i));
  assign start = enable_i && ((state == ST_IDLE) || (state == ST_GAP && due));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      mode_q         <= PWR_FAST;
      per_cnt        <= '0;
      result_o       <= '0;
      result_valid_o <= 1'b0;
      err_proto_o    <= 1'b0;
    end else begin
      result_valid_o <= 1'b0;
      err_proto_o    <= 1'b0;
      if (per_cnt != '1) per_cnt <= per_cnt + 1'b1;
      case (state)
        ST_WAIT: begin
          if (busy_fall) state <= ST_READ;
          else if (busy_to) state <= ST_GAP;
        end
        ST_READ: begin
          if (shift_done) begin
            state          <= ST_GAP;
            result_o       <= frame[DATA_W-1:0];
            result_valid_o <= 1'b1;
            err_proto_o    <= lead_nonzero(64'(frame), FRAME_BITS, LEAD_BITS);
          end
        end
        ST_GAP: begin
          if (!enable_i) state <= ST_IDLE;
        end
        default: ;
      endcase
      if (start) begin
        state   <= ST_WAIT;
        mode_q  <= pwr_mode_e'(mode_i);
        per_cnt <= '0;
      end
    end
  end

  adc_rd_convst #(
    .LOW_CYC(CNV_LOW_CYC)
  ) u_convst (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .sleep_i    (mode_q == PWR_SLEEP),
    .busy_fall_i(busy_fall),
    .abort_i    (busy_to),
    .convst_n_o (adc_convst_n_o)
  );

  adc_rd_busywatch #(
    .TIMEOUT(BUSY_TIMEOUT)
  ) u_busy (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (start),
    .busy_i    (adc_busy_i),
    .busy_lvl_o(busy_lvl),
    .fall_o    (busy_fall),
    .timeout_o (busy_to)
  );

  assign err_timeout_o = busy_to;

  adc_rd_shifter #(
    .FRAME_BITS(FRAME_BITS),
    .HI_CYC    (SCK_HI_CYC),
    .LO_CYC    (SCK_LO_CYC),
    .MIN_PHASE (SCK_MIN_PH)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (busy_fall),
    .sdata_i(adc_sdata_i),
    .sclk_o (adc_sclk_o),
    .frame_o(frame),
    .done_o (shift_done)
  );

  // R1 / R11: the strobe is high whenever the controller is idle
  a_r11_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> adc_convst_n_o);
  // R2: fast mode has released the strobe before the conversion completes
  a_r2_fast_release: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PWR_FAST && busy_fall) |-> adc_convst_n_o);
  // R3: sleep mode keeps the strobe low while waiting for busy
  a_r3_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PWR_SLEEP && state == ST_WAIT) |-> !adc_convst_n_o);
  // R4: no serial clock while the converter reports busy
  a_r4_no_clk_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_lvl |-> !adc_sclk_o);
  // R5: serial clock idles low outside readout
  a_r5_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_READ) |-> !adc_sclk_o);
  // R7: protocol error accompanies a result
  a_r7_proto_valid: assert property (@(posedge clk) disable iff (!rst_n)
    err_proto_o |-> result_valid_o);
  // R8: valid is a single-cycle pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |=> !result_valid_o);
  // R8: result holds between pulses
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid_o |-> $stable(result_o));
  // R9: a new strobe starts with the serial clock idle
  a_r9_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !adc_sclk_o);
  // R10: timeout releases the strobe and yields no result
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout_o |=> (adc_convst_n_o && !result_valid_o));

endmodule

// File: tb/adc_readout_ctrl_tb_top.sv
module adc_readout_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CONV_CYC   = 30;
  localparam int TO_CYC     = 100;
  localparam int LOW_CYC    = 4;
  localparam int HI_CYC     = 5;
  localparam int LO_CYC     = 5;

  typedef struct packed {
    logic        sleep;
    logic [15:0] period;
    logic [15:0] word;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 16'd250, 16'h0ABC},
    '{1'b1, 16'd320, 16'h0F00},
    '{1'b0, 16'd400, 16'h0001},
    '{1'b1, 16'd300, 16'h9123},
    '{1'b0, 16'd20,  16'h0800}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        mode = 1'b0;
  logic [15:0] period = 16'd100;
  logic        adc_busy;
  logic        adc_sdata;
  logic        adc_convst_n;
  logic        adc_sclk;
  logic [11:0] result;
  logic        result_valid;
  logic        err_timeout;
  logic        err_proto;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // converter model state
  int          fault = 0;   // 0 normal, 1 busy never rises, 2 busy stuck high
  logic [15:0] word_cfg = 16'h0;
  logic [15:0] sh = 16'h0;
  int          conv_left = 0;
  logic        busy_m = 1'b0;
  logic        sdata_m = 1'b0;
  logic        cnv_prev = 1'b1;
  logic        sclk_prev = 1'b0;
  int          nfalls = 0;
  int          t_last = 0;
  int          t_prev = 0;
  int          rises = 0;
  int          t_edge = 0;
  int          hi_w = 0;
  int          lo_w = 0;
  int          cnv_low_w = 0;
  logic        cnv_at_fall = 1'b0;
  logic        sclk_in_busy = 1'b0;
  int          nvalid = 0;
  int          t_to = 0;

  assign adc_busy  = busy_m;
  assign adc_sdata = sdata_m;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_readout_ctrl #(
    .CNV_LOW_CYC (LOW_CYC),
    .SCK_HI_CYC  (HI_CYC),
    .SCK_LO_CYC  (LO_CYC),
    .BUSY_TIMEOUT(TO_CYC)
  ) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable_i      (enable),
    .mode_i        (mode),
    .period_i      (period),
    .adc_busy_i    (adc_busy),
    .adc_sdata_i   (adc_sdata),
    .adc_convst_n_o(adc_convst_n),
    .adc_sclk_o    (adc_sclk),
    .result_o      (result),
    .result_valid_o(result_valid),
    .err_timeout_o (err_timeout),
    .err_proto_o   (err_proto)
  );

  // Converter model and monitor, evaluated away from the active edge
  always @(negedge clk) begin
    if (cnv_prev && !adc_convst_n) begin
      nfalls = nfalls + 1;
      t_prev = t_last;
      t_last = cyc;
      rises  = 0;
      if (fault != 1) begin
        busy_m    = 1'b1;
        conv_left = CONV_CYC;
      end
    end else if (busy_m && fault != 2) begin
      conv_left = conv_left - 1;
      if (conv_left <= 0) begin
        busy_m      = 1'b0;
        sh          = word_cfg;
        sdata_m     = sh[15];
        cnv_at_fall = adc_convst_n;
      end
    end
    if (!cnv_prev && adc_convst_n) cnv_low_w = cyc - t_last;
    if (!sclk_prev && adc_sclk) begin
      rises = rises + 1;
      if (busy_m) sclk_in_busy = 1'b1;
      lo_w   = cyc - t_edge;
      t_edge = cyc;
    end
    if (sclk_prev && !adc_sclk) begin
      sh      = sh << 1;
      sdata_m = sh[15];
      hi_w    = cyc - t_edge;
      t_edge  = cyc;
    end
    if (result_valid) nvalid = nvalid + 1;
    if (err_timeout) t_to = cyc;
    cnv_prev  = adc_convst_n;
    sclk_prev = adc_sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wait_valid(input int maxc, output bit got);
    got = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      #1;
      if (result_valid) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic wait_timeout(input int maxc, output bit got);
    got = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      #1;
      if (err_timeout) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit got;
    int v0;
    int f0;
    step(3);
    // R1: reset values
    chk(adc_convst_n === 1'b1 && adc_sclk === 1'b0, "R1 strobe/sclk",
        {adc_convst_n, adc_sclk}, 2);
    chk(result === 12'h0 && !result_valid && !err_timeout && !err_proto, "R1 outputs",
        int'(result), 0);
    rst_n = 1'b1;
    step(5);
    chk(adc_convst_n === 1'b1 && adc_sclk === 1'b0 && !result_valid, "R1 after release",
        {adc_convst_n, adc_sclk, result_valid}, 4);

    // Table of vectors
    foreach (VECS[k]) begin
      int exp_res;
      int exp_err;
      exp_res  = int'(VECS[k].word[11:0]);
      exp_err  = (VECS[k].word[15:12] != 4'h0) ? 1 : 0;
      mode     = VECS[k].sleep;
      period   = VECS[k].period;
      word_cfg = VECS[k].word;
      fault    = 0;
      sclk_in_busy = 1'b0;
      enable   = 1'b1;
      wait_valid(2000, got);
      chk(got, "R8 valid seen", int'(got), 1);
      chk(int'(result) == exp_res, "R6 result", int'(result), exp_res);
      chk(int'(err_proto) == exp_err, "R7 lead error", int'(err_proto), exp_err);
      chk(rises == 16, "R5 pulse count", rises, 16);
      chk(hi_w == HI_CYC && lo_w == LO_CYC, "R5 phase widths", hi_w * 100 + lo_w,
          HI_CYC * 100 + LO_CYC);
      chk(!sclk_in_busy, "R4 no clock while busy", int'(sclk_in_busy), 0);
      if (!VECS[k].sleep) begin
        chk(cnv_low_w == LOW_CYC, "R2 strobe width", cnv_low_w, LOW_CYC);
        chk(cnv_at_fall === 1'b1, "R2 high at busy fall", int'(cnv_at_fall), 1);
      end else begin
        chk(cnv_at_fall === 1'b0, "R3 low at busy fall", int'(cnv_at_fall), 0);
        chk(cnv_low_w > CONV_CYC, "R3 held through conversion", cnv_low_w, CONV_CYC + 1);
      end
      step(1);
      chk(!result_valid, "R8 one-cycle pulse", int'(result_valid), 0);
      wait_valid(2000, got);
      enable = 1'b0;
      chk(got, "R9 second frame", int'(got), 1);
      if (VECS[k].period >= 16'd250)
        chk(t_last - t_prev == int'(VECS[k].period), "R9 spacing", t_last - t_prev,
            int'(VECS[k].period));
      else
        chk(t_last - t_prev > 16 * (HI_CYC + LO_CYC) + CONV_CYC, "R9 waits for readout",
            t_last - t_prev, 16 * (HI_CYC + LO_CYC) + CONV_CYC + 1);
      chk(!adc_sclk, "R5 idle low after frame", int'(adc_sclk), 0);
      step(60);
    end

    // R11: disabled means no conversions
    f0 = nfalls;
    step(500);
    chk(nfalls == f0, "R11 no start while disabled", nfalls, f0);
    // R11: frame in progress completes after enable drops
    mode = 1'b0;
    period = 16'd300;
    word_cfg = 16'h0555;
    enable = 1'b1;
    while (nfalls == f0) step(1);
    enable = 1'b0;
    wait_valid(1000, got);
    chk(got && result == 12'h555, "R11 frame completes", int'(result), 'h555);
    f0 = nfalls;
    step(400);
    chk(nfalls == f0, "R11 no restart", nfalls, f0);

    // R10: busy never rises
    fault = 1;
    v0 = nvalid;
    enable = 1'b1;
    wait_timeout(TO_CYC + 50, got);
    enable = 1'b0;
    chk(got, "R10 timeout seen (silent)", int'(got), 1);
    chk(t_to - t_last == TO_CYC, "R10 timeout cycle", t_to - t_last, TO_CYC);
    step(1);
    chk(adc_convst_n === 1'b1, "R10 strobe released", int'(adc_convst_n), 1);
    step(300);
    chk(nvalid == v0, "R10 no result", nvalid - v0, 0);

    // R10: busy stuck high in sleep mode
    fault = 2;
    mode = 1'b1;
    enable = 1'b1;
    wait_timeout(TO_CYC + 50, got);
    enable = 1'b0;
    chk(got && t_to - t_last == TO_CYC, "R10 timeout (stuck)", t_to - t_last, TO_CYC);
    step(1);
    chk(adc_convst_n === 1'b1 && !adc_sclk, "R10 sleep strobe released",
        {adc_convst_n, adc_sclk}, 2);
    fault = 0;
    step(100);
    chk(nvalid == v0, "R10 no result (stuck)", nvalid - v0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule